// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block sits between a set of peripheral interrupt request lines and a small CPU core. Each of up to twelve sources is given a 2-bit priority code. Software writes these codes into three 8-bit level registers, which cannot be read back. Code 0 is the most urgent. Codes 1 and 2 are intermediate. Code 3 switches the source off. Among the requests that are asserted and enabled, the block picks the most urgent one. When several share that code, the source with the lowest number wins.

The CPU supplies its global interrupt enable and its current 2-bit level field. The controller grants the winner only when the enable is set and the winner's code is numerically below the current level field. The grant, the winning code and the winning source number are registered once before they reach the CPU. A separate wake output tells the standby logic that some enabled source is pending. It does not depend on the enable or the level field.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset every source code is 3. With any request pattern, `take_o` and `wake_o` are then 0 until a level register is written.
- R2: Level register s (`wr_sel_i` = s, s in 0..2) holds the code of source 4*s+k in bits [2k+1:2k]. A write replaces all four codes in that register, and the new codes apply from the next clock edge.
- R3: A source whose code is 3 never causes a grant or a wake, even while its request is high.
- R4: A grant is issued only when the winning code is strictly less than `cpu_il_i`. A `cpu_il_i` of 0 blocks every grant.
- R5: A grant is issued only while `cpu_ien_i` is 1.
- R6: Among pending enabled requests, the one with the numerically smallest code wins.
- R7: Among pending requests that share the smallest code, the lowest-numbered source wins.
- R8: `take_o`, `take_lvl_o` and `take_vec_o` are registered. They reflect the request, level and enable inputs of the previous cycle. `take_vec_o` is the winning source number and `take_lvl_o` is its code. Both are 0 when `take_o` is 0.
- R9: `wake_o` follows the inputs without a register. It is 1 exactly when some request is high whose code is not 3, whatever `cpu_ien_i` and `cpu_il_i` are.
- R10: A write with `wr_sel_i` = 3 (the slot of the test register) changes no source code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 12 | Interrupt request per source |
| wr_en_i | input | 1 | Level register write strobe |
| wr_sel_i | input | 2 | Register selector (0..2 level, 3 test) |
| wr_data_i | input | 8 | Write data |
| cpu_ien_i | input | 1 | CPU global interrupt enable |
| cpu_il_i | input | 2 | CPU current interrupt level field |
| take_o | output | 1 | Registered grant toward the CPU |
| take_lvl_o | output | 2 | Code of the granted source |
| take_vec_o | output | 4 | Number of the granted source |
| wake_o | output | 1 | Pending enabled request, for standby exit |

## Verification
The bench targets ties at the best code. An arbiter that scans from the top or uses `<=` would return the higher-numbered source. It also tests equality between the winning code and `cpu_il_i`, where a non-strict compare would grant a request that must wait. Requests at code 3 are mixed with urgent ones, and all requests are raised with the level field at 0, to show that wake ignores the enable and level while the grant does not. Writes to the test slot and rewrites of a whole register check field placement. An off-by-one in the field offset, or a partial update, would move a code to the wrong source.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    parameter int NUM_SRC = 12;
    parameter int LVL_W   = 2;
    parameter int REG_W   = 8;

    localparam int FLD_PER_REG = REG_W / LVL_W;
    localparam int NUM_REGS    = (NUM_SRC + FLD_PER_REG - 1) / FLD_PER_REG;
    localparam int SEL_W       = $clog2(NUM_REGS + 1);
    localparam int IDX_W       = $clog2(NUM_SRC);
    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
        lvl_t lvl;
    } win_t;

    function automatic logic lvl_beats(input lvl_t cand, input lvl_t best);
        return cand < best;
    endfunction
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output lvl_t             lvl_o [NUM_SRC]
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar k = 0; k < FLD_PER_REG; k++) begin : g_fld
            if (r * FLD_PER_REG + k < NUM_SRC) begin : g_live
                localparam int SRC = r * FLD_PER_REG + k;
                lvl_t code_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        code_q <= LVL_OFF;
                    else if (wr_en_i && (wr_sel_i == SEL_W'(r)))
                        code_q <= wr_data_i[k*LVL_W +: LVL_W];
                end
                assign lvl_o[SRC] = code_q;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_i,
    input  lvl_t               lvl_i [NUM_SRC],
    output win_t               win_o
);
    lvl_t eff [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_eff
        assign eff[i] = req_i[i] ? lvl_i[i] : LVL_OFF;
    end

    always_comb begin
        win_t best;
        best.hit = 1'b0;
        best.idx = '0;
        best.lvl = LVL_OFF;
        // Scan upward with a strict compare so the lowest index keeps a tie.
        for (int i = 0; i < NUM_SRC; i++) begin
            if (lvl_beats(eff[i], best.lvl)) begin
                best.idx = IDX_W'(i);
                best.lvl = eff[i];
            end
        end
        best.hit = (best.lvl != LVL_OFF);
        win_o = best;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic               cpu_ien_i,
    input  logic [LVL_W-1:0]   cpu_il_i,
    output logic               take_o,
    output logic [LVL_W-1:0]   take_lvl_o,
    output logic [IDX_W-1:0]   take_vec_o,
    output logic               wake_o
);
    lvl_t lvl [NUM_SRC];
    win_t win;
    logic accept;

    irq_lvl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .lvl_o     (lvl)
    );

    irq_arbiter u_arb (
        .req_i (req_i),
        .lvl_i (lvl),
        .win_o (win)
    );

    assign accept = win.hit && cpu_ien_i && lvl_beats(win.lvl, cpu_il_i);
    assign wake_o = win.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            take_lvl_o <= '0;
            take_vec_o <= '0;
        end else begin
            take_o     <= accept;
            take_lvl_o <= accept ? win.lvl : '0;
            take_vec_o <= accept ? win.idx : '0;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] req_i,
    input logic               cpu_ien_i,
    input logic [LVL_W-1:0]   cpu_il_i,
    input logic               take_o,
    input logic [LVL_W-1:0]   take_lvl_o,
    input logic [IDX_W-1:0]   take_vec_o,
    input logic               wake_o
);
    logic [NUM_SRC-1:0] req_q;
    always_ff @(posedge clk) req_q <= req_i;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!take_o && !wake_o));

    a_r4_strict_level: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (take_lvl_o < $past(cpu_il_i)));

    a_r5_enable_gate: assert property (@(posedge clk) disable iff (rst)
        !cpu_ien_i |=> !take_o);

    a_r9_take_needs_wake: assert property (@(posedge clk) disable iff (rst)
        !wake_o |=> !take_o);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (take_lvl_o == '0 && take_vec_o == '0));

    a_r8_vec_was_requested: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (take_vec_o < NUM_SRC &&
                    (|(req_q & (NUM_SRC'(1) << take_vec_o)))));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .cpu_ien_i  (cpu_ien_i),
    .cpu_il_i   (cpu_il_i),
    .take_o     (take_o),
    .take_lvl_o (take_lvl_o),
    .take_vec_o (take_vec_o),
    .wake_o     (wake_o)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] req = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        ien = 1'b0;
    logic [1:0]  il = 2'd3;
    logic        take;
    logic [1:0]  take_lvl;
    logic [3:0]  take_vec;
    logic        wake;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .cpu_ien_i  (ien),
        .cpu_il_i   (il),
        .take_o     (take),
        .take_lvl_o (take_lvl),
        .take_vec_o (take_vec),
        .wake_o     (wake)
    );

    typedef struct packed {
        logic [11:0] req;
        logic        ien;
        logic [1:0]  il;
        logic        take;
        logic [3:0]  vec;
        logic [1:0]  lvl;
        logic        wake;
    } vec_t;

    // Codes programmed: s0=2 s1=1 s2=1 s3=3 s4=0 s5=2 s6=0 s7=3 s8=1 s9=2 s10=3 s11=0
    localparam vec_t TBL [12] = '{
        '{12'h000, 1'b1, 2'd3, 1'b0, 4'd0,  2'd0, 1'b0},  // R9 nothing pending
        '{12'h001, 1'b1, 2'd3, 1'b1, 4'd0,  2'd2, 1'b1},  // R4 2<3
        '{12'h001, 1'b1, 2'd2, 1'b0, 4'd0,  2'd0, 1'b1},  // R4 equal blocks
        '{12'h006, 1'b1, 2'd2, 1'b1, 4'd1,  2'd1, 1'b1},  // R7 tie s1,s2
        '{12'h104, 1'b1, 2'd2, 1'b1, 4'd2,  2'd1, 1'b1},  // R7 tie s2,s8
        '{12'h851, 1'b1, 2'd1, 1'b1, 4'd4,  2'd0, 1'b1},  // R6 best code
        '{12'h851, 1'b0, 2'd1, 1'b0, 4'd0,  2'd0, 1'b1},  // R5 enable off
        '{12'h488, 1'b1, 2'd3, 1'b0, 4'd0,  2'd0, 1'b0},  // R3 all off
        '{12'hC00, 1'b1, 2'd1, 1'b1, 4'd11, 2'd0, 1'b1},  // R3 s10 off, s11 wins
        '{12'hFFF, 1'b1, 2'd0, 1'b0, 4'd0,  2'd0, 1'b1},  // R4 il 0
        '{12'h220, 1'b1, 2'd3, 1'b1, 4'd5,  2'd2, 1'b1},  // R7 tie s5,s9
        '{12'h220, 1'b1, 2'd2, 1'b0, 4'd0,  2'd0, 1'b1}   // R4 equal blocks
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive at negedge, check wake now, check registered grant one edge later.
    task automatic apply(input string tag, input logic [11:0] r, input logic e,
                         input logic [1:0] l, input logic t, input logic [3:0] v,
                         input logic [1:0] lv, input logic w);
        @(negedge clk);
        req = r; ien = e; il = l;
        #1;
        chk({tag, " wake"}, {7'd0, wake}, {7'd0, w});
        @(negedge clk);
        chk({tag, " take"}, {7'd0, take}, {7'd0, t});
        chk({tag, " vec"},  {4'd0, take_vec}, {4'd0, v});
        chk({tag, " lvl"},  {6'd0, take_lvl}, {6'd0, lv});
    endtask

    initial begin
        #(5 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state with every request high
        req = 12'hFFF; ien = 1'b1; il = 2'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        apply("R1 after reset", 12'hFFF, 1'b1, 2'd3, 1'b0, 4'd0, 2'd0, 1'b0);

        // R2: program all three registers
        wr(2'd0, 8'hD6);
        wr(2'd1, 8'hC8);
        wr(2'd2, 8'h39);

        for (int i = 0; i < 12; i++) begin
            apply($sformatf("R8 vector %0d", i), TBL[i].req, TBL[i].ien,
                  TBL[i].il, TBL[i].take, TBL[i].vec, TBL[i].lvl, TBL[i].wake);
        end

        // R10: test slot write must not alter any code
        wr(2'd3, 8'h00);
        apply("R10 s3/s7/s10 still off", 12'h488, 1'b1, 2'd3, 1'b0, 4'd0, 2'd0, 1'b0);
        apply("R10 s1 still code 1", 12'h002, 1'b1, 2'd3, 1'b1, 4'd1, 2'd1, 1'b1);

        // R2: whole register replaced; only s3 becomes code 0
        wr(2'd0, 8'h3F);
        apply("R2 s3 now code 0", 12'h008, 1'b1, 2'd1, 1'b1, 4'd3, 2'd0, 1'b1);
        apply("R2 s0 now off", 12'h007, 1'b1, 2'd3, 1'b0, 4'd0, 2'd0, 1'b0);
        apply("R2 s4 untouched", 12'h01F, 1'b1, 2'd1, 1'b1, 4'd3, 2'd0, 1'b1);

        // R9: wake ignores enable and level
        apply("R9 wake with ien 0", 12'h010, 1'b0, 2'd0, 1'b0, 4'd0, 2'd0, 1'b1);

        // R1: mid-run reset restores all codes to 3
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        apply("R1 codes cleared", 12'h810, 1'b1, 2'd3, 1'b0, 4'd0, 2'd0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule